// File: doc/BRIEF.md
# Nine-Level Dual-Pulse Carrier Modulator

This block produces the level command for a nine-level inverter phase leg. A free-running phase counter covers one carrier period of `PERIOD` clock cycles and splits it into four equal quarters. From the quarter index and the position inside the quarter, a 16-bit piecewise-linear carrier is formed. The carrier climbs to full scale, drops to a programmable dip `dq`, climbs back to full scale and then returns to zero. Four copies of this carrier are stacked one above the other, each in its own unit band. The magnitude of a signed reference sample, scaled by four, is compared against all four. The number of carriers lying below it is the output level.

Because the carrier returns to full scale twice, a reference whose fractional part lies above the dip yields two pulses per period. The dip is clamped below full scale, so the shape can never become a flat trapezoid. The reference is expected to already include the modulation index. The polarity bit and the period strobe travel with the level, so a downstream gate mapper can register all three together. The sine source, switch mapping and dead time lie outside this block.

Top module: `ml_pwm_mod`

## Requirements
- R1: While `rst_ni` is low, `level_o`, `sign_o` and `strobe_o` are 0. In the first cycle after the first rising clock edge following release, `strobe_o` is 1 and the outputs reflect carrier phase 0.
- R2: `strobe_o` is high for exactly one cycle out of every `PERIOD` cycles, and only when the outputs reflect phase 0.
- R3: For phase n (0..PERIOD-1), let Q = PERIOD/4, quarter s = n/Q, p = n mod Q, STEP = floor(2^32/Q) and u = floor(p*STEP/2^16). Let d be the clamped dip and span = 65536-d. The carrier c is as follows: for s=0, c = u; for s=1, c = 65535 - floor(span*u/2^16); for s=2, c = d + floor(span*u/2^16); for s=3, c = 65535 - u.
- R4: With dq = 0, the carrier in the second half period repeats the first half exactly. Each half is a plain 0 to full scale to 0 triangle.
- R5: A `dq_i` above `DQ_MAX` (default 0xF000) acts exactly as `DQ_MAX`. Values up to `DQ_MAX` are used unchanged.
- R6: `ref_i` is two's complement with 15 fraction bits. Its magnitude m saturates at 32767. Define band = m[14:13] and frac = m[12:0]·8. Carrier k (k=0..3) counts as below when k·65536 + c < band·65536 + frac. `level_o` is the count of such carriers, in the range 0..4.
- R7: `sign_o` equals bit 15 of the reference. A zero reference gives `level_o` = 0 and `sign_o` = 0.
- R8: `level_o` and `sign_o` reflect the `ref_i` and `dq_i` values present at the preceding rising edge, evaluated at the phase held at that edge. The latency is one cycle.
- R9: With dq above a reference's fractional part, `level_o` stays at the band value for the whole middle half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | REF_W (16) | Signed reference sample, Q1.15 |
| dq_i | input | 16 | Carrier dip depth, unsigned Q0.16 |
| level_o | output | 3 | Output level 0..4 |
| sign_o | output | 1 | Polarity of the level |
| strobe_o | output | 1 | Carrier period boundary |

## Verification
The period strobe and a level update both come from the same register stage, so the phase-0 sample and a reference step can land in one cycle. The bench changes `ref_i` and `dq_i` on every cycle across several period wraps. It compares each cycle's level, sign and strobe against a model driven by the bench's own edge count. A wrong wrap position or an extra pipeline stage shows up as a mismatch in exactly those boundary cycles.

// File: rtl/ml_pwm_pkg.sv
package ml_pwm_pkg;
  localparam int AMP_W  = 16;
  localparam int FRAC_W = 16;
  localparam int BANDS  = 4;
  localparam int BAND_W = $clog2(BANDS);
  localparam int LVL_W  = $clog2(BANDS + 1);

  typedef enum logic [1:0] {
    SEG_RISE = 2'd0,
    SEG_DROP = 2'd1,
    SEG_LIFT = 2'd2,
    SEG_FALL = 2'd3
  } seg_e;

  typedef logic [AMP_W-1:0] amp_t;
endpackage

// File: rtl/ml_pwm_phase.sv
module ml_pwm_phase
  import ml_pwm_pkg::*;
#(
  parameter int PERIOD = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output seg_e seg_o,
  output amp_t ramp_o,
  output logic wrap_o
);
  localparam int QLEN  = PERIOD / 4;
  localparam int POS_W = (QLEN > 1) ? $clog2(QLEN) : 1;
  localparam int ACC_W = AMP_W + FRAC_W;
  localparam logic [ACC_W-1:0] STEP = ACC_W'((64'd1 << ACC_W) / 64'(QLEN));
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(QLEN - 1);

  seg_e             seg_q;
  logic [1:0]       seg_nx;
  logic [POS_W-1:0] pos_q;
  logic [ACC_W-1:0] acc_q;

  assign seg_nx = seg_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_RISE;
      pos_q <= '0;
      acc_q <= '0;
    end else if (pos_q == POS_LAST) begin
      seg_q <= seg_e'(seg_nx);
      pos_q <= '0;
      acc_q <= '0;
    end else begin
      pos_q <= pos_q + 1'b1;
      acc_q <= acc_q + STEP;
    end
  end

  assign seg_o  = seg_q;
  assign ramp_o = AMP_W'(acc_q >> FRAC_W);
  assign wrap_o = (seg_q == SEG_RISE) && (pos_q == '0);
endmodule

// File: rtl/ml_pwm_carrier.sv
module ml_pwm_carrier
  import ml_pwm_pkg::*;
#(
  parameter logic [15:0] DQ_MAX = 16'hF000
) (
  input  seg_e seg_i,
  input  amp_t ramp_i,
  input  amp_t dq_i,
  output amp_t carrier_o
);
  localparam int PROD_W = 2 * AMP_W + 1;
  localparam amp_t FULL = '1;

  amp_t              dq_eff;
  logic [AMP_W:0]    span;
  logic [PROD_W-1:0] prod;
  amp_t              scaled;

  // dip must stay under full scale or the two pulses merge into one
  assign dq_eff = (dq_i > amp_t'(DQ_MAX)) ? amp_t'(DQ_MAX) : dq_i;
  assign span   = (AMP_W+1)'(1 << AMP_W) - {1'b0, dq_eff};
  assign prod   = PROD_W'(span) * PROD_W'(ramp_i);
  assign scaled = AMP_W'(prod >> AMP_W);

  always_comb begin
    unique case (seg_i)
      SEG_RISE: carrier_o = ramp_i;
      SEG_DROP: carrier_o = FULL - scaled;
      SEG_LIFT: carrier_o = dq_eff + scaled;
      default:  carrier_o = FULL - ramp_i;
    endcase
  end
endmodule

// File: rtl/ml_pwm_slice.sv
module ml_pwm_slice
  import ml_pwm_pkg::*;
#(
  parameter int REF_W = 16
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  amp_t                    carrier_i,
  output logic [LVL_W-1:0]        level_o,
  output logic                    sign_o
);
  localparam int MAG_W  = REF_W - 1;
  localparam int FBIT_W = MAG_W - BAND_W;
  localparam int PAD_W  = AMP_W - FBIT_W;
  localparam int CMP_W  = BAND_W + AMP_W;

  logic [REF_W-1:0] neg_val;
  logic [MAG_W-1:0] mag;
  logic [CMP_W-1:0] target;
  logic [BANDS-1:0] below;

  assign neg_val = -ref_i;

  always_comb begin
    if (!ref_i[REF_W-1])                                  mag = ref_i[MAG_W-1:0];
    else if (ref_i == {1'b1, {(REF_W-1){1'b0}}})          mag = '1;
    else                                                  mag = neg_val[MAG_W-1:0];
  end

  // band in the top bits, fraction widened to carrier precision
  assign target = {mag, {PAD_W{1'b0}}};

  for (genvar k = 0; k < BANDS; k++) begin : g_band
    assign below[k] = {BAND_W'(k), carrier_i} < target;
  end

  always_comb begin
    level_o = '0;
    for (int k = 0; k < BANDS; k++) level_o = level_o + LVL_W'(below[k]);
  end

  assign sign_o = ref_i[REF_W-1];
endmodule

// File: rtl/ml_pwm_mod.sv
module ml_pwm_mod
  import ml_pwm_pkg::*;
#(
  parameter int          PERIOD = 100000,
  parameter int          REF_W  = 16,
  parameter logic [15:0] DQ_MAX = 16'hF000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [15:0]             dq_i,
  output logic [LVL_W-1:0]        level_o,
  output logic                    sign_o,
  output logic                    strobe_o
);
  seg_e             seg;
  amp_t             ramp;
  amp_t             carrier;
  logic             wrap;
  logic [LVL_W-1:0] level_d;
  logic             sign_d;
  logic [LVL_W-1:0] level_q;
  logic             sign_q;
  logic             strobe_q;

  ml_pwm_phase #(.PERIOD(PERIOD)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seg_o  (seg),
    .ramp_o (ramp),
    .wrap_o (wrap)
  );

  ml_pwm_carrier #(.DQ_MAX(DQ_MAX)) u_carrier (
    .seg_i     (seg),
    .ramp_i    (ramp),
    .dq_i      (dq_i),
    .carrier_o (carrier)
  );

  ml_pwm_slice #(.REF_W(REF_W)) u_slice (
    .ref_i     (ref_i),
    .carrier_i (carrier),
    .level_o   (level_d),
    .sign_o    (sign_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= '0;
      sign_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      level_q  <= level_d;
      sign_q   <= sign_d;
      strobe_q <= wrap;
    end
  end

  assign level_o  = level_q;
  assign sign_o   = sign_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/ml_pwm_chk.sv
module ml_pwm_chk #(
  parameter int PERIOD = 100000,
  parameter int REF_W  = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic signed [REF_W-1:0] ref_i,
  input logic [2:0]              level_o,
  input logic                    sign_o,
  input logic                    strobe_o
);
  localparam int GAP_W = $clog2(PERIOD) + 1;

  logic signed [REF_W-1:0] ref_d;
  logic [GAP_W-1:0]        gap;
  logic                    seen;
  logic                    armed;
  logic [2:0]              band_d;

  function automatic logic [2:0] band_of(input logic signed [REF_W-1:0] r);
    int unsigned m;
    m = (r < 0) ? int'(-int'(r)) : int'(r);
    if (m > (2 ** (REF_W - 1)) - 1) m = (2 ** (REF_W - 1)) - 1;
    return 3'(m >> (REF_W - 3));
  endfunction

  assign band_d = band_of(ref_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_d <= '0;
      gap   <= '0;
      seen  <= 1'b0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      ref_d <= ref_i;
      if (strobe_o) begin
        gap  <= '0;
        seen <= 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_FIRST_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !seen) |-> strobe_o);  // R1
  AST_STROBE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && strobe_o) |-> (gap == GAP_W'(PERIOD - 1)));  // R2
  AST_STROBE_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap < GAP_W'(PERIOD));  // R2
  AST_LEVEL_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (level_o >= band_d && level_o <= band_d + 3'd1 && level_o <= 3'd4));  // R6
  AST_ZERO_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ref_d == '0) |-> (level_o == 3'd0 && !sign_o));  // R7
  AST_SIGN_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (sign_o == ref_d[REF_W-1]));  // R7
endmodule

bind ml_pwm_mod ml_pwm_chk #(.PERIOD(PERIOD), .REF_W(REF_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ref_i    (ref_i),
  .level_o  (level_o),
  .sign_o   (sign_o),
  .strobe_o (strobe_o)
);

// File: tb/ml_pwm_mod_bench.sv
`timescale 1ns/1ps
module ml_pwm_mod_bench;
  localparam int PERIOD = 64;
  localparam int Q      = PERIOD / 4;
  localparam int DQ_MAX = 'hF000;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [15:0] ref_i = '0;
  logic [15:0]        dq_i = '0;
  logic [2:0]         level_o;
  logic               sign_o;
  logic               strobe_o;

  int n_chk  = 0;
  int n_fail = 0;
  int edges  = 0;
  int lv_a [PERIOD];
  int lv_b [PERIOD];

  always #2 clk_i = ~clk_i;

  ml_pwm_mod #(.PERIOD(PERIOD), .REF_W(16), .DQ_MAX(16'hF000)) u_ml_pwm_mod (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_i    (ref_i),
    .dq_i     (dq_i),
    .level_o  (level_o),
    .sign_o   (sign_o),
    .strobe_o (strobe_o)
  );

  function automatic int m_carrier(int ph, int dq);
    longint step, u, sc, d, span;
    int s, p;
    s = ph / Q;
    p = ph % Q;
    step = (longint'(1) << 32) / Q;
    u = (longint'(p) * step) >> 16;
    d = (dq > DQ_MAX) ? DQ_MAX : dq;
    span = 65536 - d;
    sc = (span * u) >> 16;
    case (s)
      0:       return int'(u);
      1:       return int'(65535 - sc);
      2:       return int'(d + sc);
      default: return int'(65535 - u);
    endcase
  endfunction

  function automatic int m_level(int r, int c);
    int m, band, frac;
    m = (r < 0) ? -r : r;
    if (m > 32767) m = 32767;
    if (m == 0) return 0;
    band = m >> 13;
    frac = (m & 8191) << 3;
    return band + ((frac > c) ? 1 : 0);
  endfunction

  task automatic chk(int got, int exp, string req, string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    edges++;
    @(negedge clk_i);
  endtask

  // one cycle with inputs held; checks all outputs against the model
  task automatic step_chk(string req, output int lvl);
    int ph, r, d;
    r = int'(ref_i);
    d = int'(dq_i);
    tick();
    ph = (edges - 1) % PERIOD;
    chk(int'(level_o), m_level(r, m_carrier(ph, d)), req, "level");
    chk(int'(sign_o), (r < 0) ? 1 : 0, "R7", "sign");
    chk(int'(strobe_o), (ph == 0) ? 1 : 0, "R2", "strobe");
    lvl = int'(level_o);
  endtask

  task automatic run_period(int r, int d, string req, output int lv [PERIOD]);
    int l;
    ref_i = 16'(r);
    dq_i = 16'(d);
    while ((edges % PERIOD) != 0) step_chk(req, l);
    for (int i = 0; i < PERIOD; i++) begin
      step_chk(req, l);
      lv[i] = l;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    ref_i = 16'sd12000;
    dq_i = 16'h4000;
    repeat (3) begin
      @(negedge clk_i);
      chk(int'(level_o), 0, "R1", "reset level");
      chk(int'(sign_o), 0, "R1", "reset sign");
      chk(int'(strobe_o), 0, "R1", "reset strobe");
    end
    rst_ni = 1'b1;
    edges = 0;
    tick();
    chk(int'(strobe_o), 1, "R1", "first strobe");
    chk(int'(level_o), m_level(12000, m_carrier(0, 'h4000)), "R1", "first level");
  endtask

  task automatic t_sweep();
    int refs [6] = '{6554, -14746, 22938, -31130, 32767, -32768};
    foreach (refs[i]) run_period(refs[i], 'h8000, "R6", lv_a);
    run_period(8000, 'h3000, "R3", lv_a);
  endtask

  task automatic t_zero();
    run_period(0, 'h8000, "R7", lv_a);
    for (int i = 0; i < PERIOD; i++) chk(lv_a[i], 0, "R7", "zero ref level");
  endtask

  task automatic t_triangle();
    run_period(9000, 0, "R4", lv_a);
    for (int i = 0; i < PERIOD / 2; i++)
      chk(lv_a[i + PERIOD / 2], lv_a[i], "R4", "half repeat");
  endtask

  task automatic t_dip();
    int hi;
    // frac about 0.3, dip 0.5: no pulse in the middle half
    run_period(2458, 'h8000, "R9", lv_a);
    hi = 0;
    for (int i = Q; i < 3 * Q; i++) hi += lv_a[i];
    chk(hi, 0, "R9", "middle half high count");
    run_period(2458, 0, "R9", lv_b);
    hi = 0;
    for (int i = Q; i < 3 * Q; i++) hi += lv_b[i];
    chk((hi > 0) ? 1 : 0, 1, "R9", "no dip gives middle pulses");
  endtask

  task automatic t_clamp();
    run_period(20000, 'hFFFF, "R5", lv_a);
    run_period(20000, DQ_MAX, "R5", lv_b);
    for (int i = 0; i < PERIOD; i++) chk(lv_a[i], lv_b[i], "R5", "clamped dip");
  endtask

  task automatic t_latency();
    int l;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      ref_i = 16'((i * 7919) % 65536 - 32768);
      dq_i = 16'((i * 4099) % 65536);
      step_chk("R8", l);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep();
    t_zero();
    t_triangle();
    t_dip();
    t_clamp();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule